// File: doc/BRIEF.md
# Keyed-Service System Watchdog

This block guards a system against runaway software. Once software sets its enable bit, it counts system clock cycles toward a selectable limit. Software restarts the count by writing an exact two-byte key to a service register. A stray write cannot do it, and neither can a single byte.

When the count reaches the limit, the block does one of two things, chosen at configuration time:
- raise a sticky interrupt request at the highest level (7), together with a programmable vector number;
- issue a one-cycle system reset request and record that cause in a reset-status register.

Software clears the recorded cause flags by writing 1 to them. The control register locks once the watchdog is enabled, so errant code cannot disable or slow it.

The host reaches four byte registers through a simple write strobe with a 2-bit address. Reads are combinational.

| Address | Register |
|---|---|
| 0 | control |
| 1 | service key |
| 2 | vector |
| 3 | reset status |

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_ni` is released, the registers read as follows: control 0x00, vector 0x0F, reset status 0x80 (hard-reset flag, bit 7, set). Both `irq_o` and `rst_req_o` are low.
- R2: While control bit 7 is 0, the block never raises `irq_o` or `rst_req_o`, however long it runs.
- R3: Writing control with bit 7 set at clock edge E starts the count. The timeout fires at edge E+2^(10+2*s), where s is control bits 4:3, giving 1024, 4096, 16384 or 65536 clocks. `irq_o` is low in the cycle just before that edge.
- R4: Control bit 2 puts a divide-by-2^PRE_LOG2 prescaler in front of the counter (default 512), which multiplies the timeout by that factor.
- R5: A write of 0x55 to address 1, then a write of 0xAA to address 1, restarts the count at the 0xAA edge and drops a pending `irq_o` there. Writes to other addresses between the two bytes do not break the pair.
- R6: A write of 0xAA to address 1 that does not directly follow a 0x55 there has no effect. Any other value written after a 0x55 discards the pending 0x55.
- R7: With control bit 6 = 0, the timeout raises `irq_o`, which stays high until a valid key pair. `irq_level_o` is always 7, and `irq_vector_o` presents the vector register.
- R8: With control bit 6 = 1, each timeout gives a one-cycle `rst_req_o` pulse and no `irq_o`. It sets status bit 5 on the next edge. The count restarts, so pulses recur every period.
- R9: Once control bit 7 is set, writes to control are ignored until `rst_ni`.
- R10: Writing 1 to status bit 7 or bit 5 clears that flag. Writing 0 to a flag leaves it unchanged.
- R11: Control keeps only bits 7, 6, 4, 3 and 2. Unused control bits, unused status bits and the service address all read 0. The vector register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Sticky watchdog interrupt request |
| irq_level_o | output | 3 | Interrupt level, fixed at 7 |
| irq_vector_o | output | 8 | Vector number for the interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Each timeout selection is run, with and without the prescaler, and checked one cycle before and exactly at the expected edge. This tells an off-by-one count, and a wrong limit decode, from correct behaviour.

Several service byte orders are applied:
- a lone 0xAA;
- 0x55, then a foreign byte, then 0xAA;
- 0x55, then a write to another register, then 0xAA;
- a correct pair issued part-way through a period.

These separate a real ordered-key detector from one that accepts any 0xAA or resets on unrelated writes, and show that the count truly restarts. Reset mode is run over two periods to tell a recurring pulse from a one-shot. Status writes of 0 and of 1 tell write-1-to-clear apart from plain storage.

// File: rtl/keyed_wdg_pkg.sv
package keyed_wdg_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SVC  = 2'd1,
    REG_VEC  = 2'd2,
    REG_STS  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN   = 7;
  localparam int unsigned CTRL_RSTM = 6;
  localparam int unsigned CTRL_SELH = 4;
  localparam int unsigned CTRL_SELL = 3;
  localparam int unsigned CTRL_PRE  = 2;
  localparam logic [7:0]  CTRL_KEEP = 8'hDC;

  localparam int unsigned STS_HARD  = 7;
  localparam int unsigned STS_WDOG  = 5;
  localparam logic [7:0]  STS_KEEP  = 8'hA0;
  localparam logic [7:0]  STS_INIT  = 8'h80;

  localparam logic [7:0]  VEC_INIT  = 8'h0F;
  localparam logic [7:0]  KEY_FIRST = 8'h55;
  localparam logic [7:0]  KEY_LAST  = 8'hAA;
  localparam logic [2:0]  WDG_LEVEL = 3'd7;

  typedef struct packed {
    logic       en;
    logic       rst_mode;
    logic [1:0] sel;
    logic       pre_en;
  } wdg_cfg_t;

endpackage

// File: rtl/keyed_wdg_key.sv
module keyed_wdg_key
  import keyed_wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       svc_o
);

  logic armed_q;

  assign svc_o = wr_i && armed_q && (data_i == KEY_LAST);

  // any service write re-evaluates the arm; only the first key arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_FIRST);
  end

  a_r6_foreign_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i != KEY_FIRST) |=> !svc_o);

endmodule

// File: rtl/keyed_wdg_timer.sv
module keyed_wdg_timer
  import keyed_wdg_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned PRE_LOG2  = 9
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdg_cfg_t cfg_i,
  input  logic     svc_i,
  output logic     irq_o,
  output logic     rst_req_o
);

  localparam int unsigned NUM_SEL = 4;
  localparam int unsigned CNT_W   = BASE_LOG2 + (NUM_SEL - 1) * STEP_LOG2;

  logic [CNT_W-1:0]    lim_tab [NUM_SEL];
  logic [CNT_W-1:0]    lim, cnt_q;
  logic [PRE_LOG2-1:0] pre_q;
  logic                tick, irq_q, rst_req_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tab[g] = {CNT_W{1'b1}} >> (STEP_LOG2 * (NUM_SEL - 1 - g));
  end

  assign lim  = lim_tab[cfg_i.sel];
  assign tick = cfg_i.en && (!cfg_i.pre_en || (pre_q == {PRE_LOG2{1'b1}}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pre_q     <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (!cfg_i.en) begin
      cnt_q     <= '0;
      pre_q     <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (svc_i) begin
        cnt_q <= '0;
        pre_q <= '0;
        irq_q <= 1'b0;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (tick) begin
          if (cnt_q == lim) begin
            cnt_q <= '0;
            if (cfg_i.rst_mode) rst_req_q <= 1'b1;
            else                irq_q     <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_req_q;

  a_r7_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !svc_i) |=> irq_q);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> (!irq_q && !rst_req_q));

  a_r8_no_irq_in_rst_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.rst_mode && !irq_q) |=> !irq_q);

endmodule

// File: rtl/keyed_wdg_regs.sv
module keyed_wdg_regs
  import keyed_wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wdog_rst_i,
  output wdg_cfg_t   cfg_o,
  output logic       svc_wr_o,
  output logic [7:0] vec_o,
  output logic [7:0] rdata_o
);

  logic [7:0] ctrl_q, vec_q, sts_q, sts_clr, sts_set;
  logic       wr_ctrl, wr_vec, wr_sts;

  assign wr_ctrl  = we_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign svc_wr_o = we_i && (reg_sel_e'(addr_i) == REG_SVC);
  assign wr_vec   = we_i && (reg_sel_e'(addr_i) == REG_VEC);
  assign wr_sts   = we_i && (reg_sel_e'(addr_i) == REG_STS);

  assign sts_clr = wr_sts ? (wdata_i & STS_KEEP) : 8'h00;
  assign sts_set = wdog_rst_i ? (8'h01 << STS_WDOG) : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
      vec_q  <= VEC_INIT;
      sts_q  <= STS_INIT;
    end else begin
      // locked after enable until hard reset
      if (wr_ctrl && !ctrl_q[CTRL_EN]) ctrl_q <= wdata_i & CTRL_KEEP;
      if (wr_vec) vec_q <= wdata_i;
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  assign cfg_o.en       = ctrl_q[CTRL_EN];
  assign cfg_o.rst_mode = ctrl_q[CTRL_RSTM];
  assign cfg_o.sel      = ctrl_q[CTRL_SELH:CTRL_SELL];
  assign cfg_o.pre_en   = ctrl_q[CTRL_PRE];
  assign vec_o          = vec_q;

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_CTRL: rdata_o = ctrl_q;
      REG_SVC:  rdata_o = 8'h00;
      REG_VEC:  rdata_o = vec_q;
      REG_STS:  rdata_o = sts_q;
      default:  rdata_o = 8'h00;
    endcase
  end

  a_r9_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_EN] |=> $stable(ctrl_q));

  a_r8_flag_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_i |=> sts_q[STS_WDOG]);

  a_r10_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_sts && !wdog_rst_i) |=> $stable(sts_q));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_wdg_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned PRE_LOG2  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic [2:0] irq_level_o,
  output logic [7:0] irq_vector_o,
  output logic       rst_req_o
);

  wdg_cfg_t cfg;
  logic     svc_wr, svc, wdog_rst;

  keyed_wdg_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wdog_rst_i (wdog_rst),
    .cfg_o      (cfg),
    .svc_wr_o   (svc_wr),
    .vec_o      (irq_vector_o),
    .rdata_o    (rdata_o)
  );

  keyed_wdg_key i_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (svc_wr),
    .data_i (wdata_i),
    .svc_o  (svc)
  );

  keyed_wdg_timer #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .PRE_LOG2  (PRE_LOG2)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .svc_i     (svc),
    .irq_o     (irq_o),
    .rst_req_o (wdog_rst)
  );

  assign rst_req_o   = wdog_rst;
  assign irq_level_o = WDG_LEVEL;

  a_r5_key_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> (!irq_o && !rst_req_o));

endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

  localparam int unsigned PRE_LOG2 = 2;
  localparam int MAX_CYC = 200000;

  localparam int W_RDATA = 0;
  localparam int W_IRQ   = 1;
  localparam int W_RST   = 2;
  localparam int W_VEC   = 3;
  localparam int W_LVL   = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SVC  = 2'd1;
  localparam logic [1:0] A_VEC  = 2'd2;
  localparam logic [1:0] A_STS  = 2'd3;

  typedef struct {
    int         cyc;
    int         what;
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, rst_req;
  logic [2:0] lvl;
  logic [7:0] vec;

  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  keyed_watchdog #(.PRE_LOG2(PRE_LOG2)) i_keyed_watchdog (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .we_i         (we),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .irq_o        (irq),
    .irq_level_o  (lvl),
    .irq_vector_o (vec),
    .rst_req_o    (rst_req)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // monitor: compare scoreboard items due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t it;
      logic [7:0] got;
      it = q.pop_front();
      case (it.what)
        W_RDATA: got = rdata;
        W_IRQ:   got = {7'd0, irq};
        W_RST:   got = {7'd0, rst_req};
        W_VEC:   got = vec;
        default: got = {5'd0, lvl};
      endcase
      nchk++;
      if (it.cyc != cyc || got !== it.val) begin
        nfail++;
        $display("FAIL %s: item %0d at cycle %0d (due %0d) got 0x%02h expected 0x%02h",
                 it.tag, it.what, cyc, it.cyc, got, it.val);
      end
    end
  end

  task automatic push(input int c, input int what, input logic [7:0] v, input string tag);
    exp_t it;
    it.cyc = c; it.what = what; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] v, input string tag);
    @(posedge clk); #1;
    addr = a;
    push(cyc, W_RDATA, v, tag);
    @(negedge clk);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  task automatic hard_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    while (cyc < MAX_CYC && !done) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int e, s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R11 service reads zero, R7 level
    rd(A_CTRL, 8'h00, "R1");
    rd(A_SVC,  8'h00, "R11");
    rd(A_VEC,  8'h0F, "R1");
    rd(A_STS,  8'h80, "R1");
    push(cyc, W_IRQ, 8'd0, "R1");
    push(cyc, W_RST, 8'd0, "R1");
    push(cyc, W_LVL, 8'd7, "R7");
    @(negedge clk);

    // R10 write-1-to-clear
    wr(A_STS, 8'h20);
    rd(A_STS, 8'h80, "R10");
    wr(A_STS, 8'h80);
    rd(A_STS, 8'h00, "R10");

    // R2 disabled never times out
    wr(A_CTRL, 8'h00);
    e = cyc;
    push(e + 1100, W_IRQ, 8'd0, "R2");
    push(e + 2000, W_IRQ, 8'd0, "R2");
    push(e + 2000, W_RST, 8'd0, "R2");
    wait_to(e + 2000);
    @(negedge clk);

    // R11 vector read back, R7 vector output
    wr(A_VEC, 8'h40);
    rd(A_VEC, 8'h40, "R11");
    push(cyc, W_VEC, 8'h40, "R7");
    @(negedge clk);

    // R3 shortest timeout, R7 sticky irq
    wr(A_CTRL, 8'h80);
    e = cyc;
    push(e + 1023, W_IRQ, 8'd0, "R3");
    push(e + 1024, W_IRQ, 8'd1, "R3");
    push(e + 1024, W_RST, 8'd0, "R7");
    push(e + 1324, W_IRQ, 8'd1, "R7");
    wait_to(e + 1324);
    @(negedge clk);

    // R9 lock
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, 8'h80, "R9");

    // R6 bad sequences
    wr(A_SVC, 8'hAA);
    push(cyc, W_IRQ, 8'd1, "R6");
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'h12);
    wr(A_SVC, 8'hAA);
    push(cyc, W_IRQ, 8'd1, "R6");
    @(negedge clk);

    // R5 valid pair with an unrelated write between
    wr(A_SVC, 8'h55);
    wr(A_VEC, 8'h41);
    wr(A_SVC, 8'hAA);
    s = cyc;
    push(s, W_IRQ, 8'd0, "R5");
    push(s, W_VEC, 8'h41, "R7");
    push(s + 1023, W_IRQ, 8'd0, "R5");
    push(s + 1024, W_IRQ, 8'd1, "R5");
    wait_to(s + 1024);
    @(negedge clk);

    // R5 restart part-way through a period
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'hAA);
    s = cyc;
    push(s, W_IRQ, 8'd0, "R5");
    wait_to(s + 600);
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'hAA);
    s = cyc;
    push(s + 1023, W_IRQ, 8'd0, "R5");
    push(s + 1024, W_IRQ, 8'd1, "R5");
    wait_to(s + 1024);
    @(negedge clk);

    // R4 prescaler (bench divide = 4)
    hard_reset();
    wr(A_CTRL, 8'h84);
    e = cyc;
    push(e + 4095, W_IRQ, 8'd0, "R4");
    push(e + 4096, W_IRQ, 8'd1, "R4");
    wait_to(e + 4096);
    @(negedge clk);

    // R11 masked control bits, R3 selection 2
    hard_reset();
    wr(A_CTRL, 8'h13);
    rd(A_CTRL, 8'h10, "R11");
    wr(A_CTRL, 8'h90);
    e = cyc;
    push(e + 16383, W_IRQ, 8'd0, "R3");
    push(e + 16384, W_IRQ, 8'd1, "R3");
    wait_to(e + 16384);
    @(negedge clk);

    // R3 selection 3
    hard_reset();
    wr(A_CTRL, 8'h98);
    e = cyc;
    push(e + 65535, W_IRQ, 8'd0, "R3");
    push(e + 65536, W_IRQ, 8'd1, "R3");
    wait_to(e + 65536);
    @(negedge clk);

    // R8 reset mode, recurring pulses, status flag
    hard_reset();
    wr(A_STS, 8'h80);
    wr(A_CTRL, 8'hC0);
    e = cyc;
    push(e + 1023, W_RST, 8'd0, "R8");
    push(e + 1024, W_RST, 8'd1, "R8");
    push(e + 1024, W_IRQ, 8'd0, "R8");
    push(e + 1025, W_RST, 8'd0, "R8");
    push(e + 2048, W_RST, 8'd1, "R8");
    push(e + 2048, W_IRQ, 8'd0, "R8");
    wait_to(e + 2048);
    @(negedge clk);
    rd(A_STS, 8'h20, "R8");
    wr(A_STS, 8'h80);
    rd(A_STS, 8'h20, "R10");
    wr(A_STS, 8'h20);
    rd(A_STS, 8'h00, "R10");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule